// File: doc/BRIEF.md
# Selectable-Timebase Pin Glitch Filter

This block cleans up a single slow input pin before it reaches edge or level detection logic. The raw pin is first brought into the core clock domain through a short flop chain. It is then held against a stability window. A new level is passed on only after it has stayed unchanged for the whole window. A shorter excursion is thrown away, and the filtered level keeps its old value.

The window is measured in ticks of a slow real-time reference. Software supplies that reference as a one-cycle `rtcTick` strobe that is already in the core clock domain. Two timebase bits pick how many ticks make one window unit, and a 4-bit count gives the number of units. One configuration therefore covers windows from a few tens of microseconds up to about a second. A 2-bit filter-type field of zero turns filtering off, and the synchronized pin then passes straight through. Each change of the filtered level also raises a one-cycle strobe for the interrupt logic downstream.

Top module: `pin_debounce`

## Requirements
- R1: After reset, `pinLevel` and `pinChange` are 0 and the stored configuration is type 0 (pass-through) with count 0 and both timebase bits 0.
- R2: The raw pin passes through a chain of two flops before any other use. A pin change made before a clock edge therefore reaches the filter after the second edge.
- R3: With filter type 0, `pinLevel` takes the new value on the third rising edge after `pinRaw` changes, and it ignores `rtcTick`.
- R4: One window unit is a number of `rtcTick` pulses that depends on {`cfgLarge`,`cfgFine`}: 00 gives 2, 01 gives 8, 10 gives 512 and 11 gives 2048.
- R5: With a nonzero filter type, a synchronized level that differs from `pinLevel` is adopted on the edge that carries the tick completing (`cfgCount`+1) units. The ticks are counted from when the difference appears, and the level is never adopted one tick earlier.
- R6: If the synchronized pin returns to `pinLevel` before the window completes, the progress is discarded. A later difference then needs a full window again.
- R7: A configuration write (`cfgWrite` high for one cycle) clears the prescaler and the unit counter, so an ongoing difference needs a full window under the written settings.
- R8: `pinChange` is high for exactly the one cycle in which `pinLevel` holds a value different from the cycle before, and it is low otherwise.
- R9: Filter type values 1, 2 and 3 all select the same stability filter.
- R10: Ticks that arrive while the synchronized pin equals `pinLevel` do not advance the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rtcTick | input | 1 | One-cycle strobe per real-time reference period, already synchronized |
| cfgWrite | input | 1 | Loads the four configuration fields below |
| cfgCount | input | 4 | Window length minus one, in units |
| cfgLarge | input | 1 | Timebase select, upper bit |
| cfgFine | input | 1 | Timebase select, lower bit |
| cfgMode | input | 2 | Filter type: 0 pass-through, otherwise stability filter |
| pinRaw | input | 1 | Asynchronous pin input |
| pinLevel | output | 1 | Filtered pin level |
| pinChange | output | 1 | One-cycle strobe when `pinLevel` changes |

## Verification
The bench covers every timebase setting with the shortest, a middle and the longest count. Each time it stops one tick short of the window and then on the completing tick. A wrong prescale ratio, or an off-by-one in the count comparison, therefore shows up as a level that moves early or late. It cuts a pending window with a brief return to the old level, and separately with a configuration rewrite. A design that kept its count through either event would accept the level too soon. It also sends ticks while the pin is steady, which would shorten the next window if stray counting leaked in. Finally, it times pass-through mode to the exact edge, so a missing or extra synchronizer stage is caught.

// File: rtl/pin_debounce_pkg.sv
package pin_debounce_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic take;   // load the synchronized level into the filtered output
  } dbStrobe_t;

endpackage

// File: rtl/pin_debounce_ctrl.sv
module pin_debounce_ctrl
  import pin_debounce_pkg::*;
#(
  parameter int COUNT_W = 4,
  parameter int MODE_W  = 2,
  parameter int SHIFT0  = 1,
  parameter int SHIFT1  = 3,
  parameter int SHIFT2  = 9,
  parameter int SHIFT3  = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rtcTick,
  input  logic               cfgWrite,
  input  logic [COUNT_W-1:0] cfgCount,
  input  logic               cfgLarge,
  input  logic               cfgFine,
  input  logic [MODE_W-1:0]  cfgMode,
  input  logic               mismatch,
  output dbStrobe_t          strobes
);

  localparam int PRE_W = SHIFT3;
  localparam logic [PRE_W-1:0] LIM0 = PRE_W'((1 << SHIFT0) - 1);
  localparam logic [PRE_W-1:0] LIM1 = PRE_W'((1 << SHIFT1) - 1);
  localparam logic [PRE_W-1:0] LIM2 = PRE_W'((1 << SHIFT2) - 1);
  localparam logic [PRE_W-1:0] LIM3 = PRE_W'((1 << SHIFT3) - 1);

  logic [COUNT_W-1:0] countQ;
  logic               largeQ;
  logic               fineQ;
  logic [MODE_W-1:0]  modeQ;
  logic [PRE_W-1:0]   preCnt;
  logic [COUNT_W-1:0] unitCnt;
  logic [PRE_W-1:0]   preLimit;
  logic               bypass;
  logic               unitDone;
  logic               windowDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      largeQ <= 1'b0;
      fineQ  <= 1'b0;
      modeQ  <= '0;
    end else if (cfgWrite) begin
      countQ <= cfgCount;
      largeQ <= cfgLarge;
      fineQ  <= cfgFine;
      modeQ  <= cfgMode;
    end
  end

  always_comb begin
    case ({largeQ, fineQ})
      2'b00:   preLimit = LIM0;
      2'b01:   preLimit = LIM1;
      2'b10:   preLimit = LIM2;
      default: preLimit = LIM3;
    endcase
  end

  assign bypass     = (modeQ == '0);
  assign unitDone   = rtcTick && (preCnt == preLimit);
  assign windowDone = unitDone && (unitCnt == countQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      unitCnt <= '0;
    end else if (cfgWrite || bypass || !mismatch) begin
      preCnt  <= '0;
      unitCnt <= '0;
    end else if (rtcTick) begin
      if (unitDone) begin
        preCnt  <= '0;
        unitCnt <= windowDone ? '0 : unitCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.take = bypass || (mismatch && windowDone && !cfgWrite);
  end

  assert_prescale_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preLimit);

  assert_unit_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    unitCnt <= countQ);

  assert_restart_on_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (preCnt == '0 && unitCnt == '0));

  assert_idle_no_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    !mismatch |=> (preCnt == '0 && unitCnt == '0));

endmodule

// File: rtl/pin_debounce_dp.sv
module pin_debounce_dp
  import pin_debounce_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pinRaw,
  input  dbStrobe_t strobes,
  output logic      mismatch,
  output logic      pinLevel,
  output logic      pinChange
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinSync;

  generate
    for (genvar stage = 0; stage < SYNC_STAGES; stage++) begin : gSync
      if (stage == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= pinRaw;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[stage] <= 1'b0;
          else       syncQ[stage] <= syncQ[stage-1];
        end
      end
    end
  endgenerate

  assign pinSync  = syncQ[SYNC_STAGES-1];
  assign mismatch = (pinSync != pinLevel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinLevel  <= 1'b0;
      pinChange <= 1'b0;
    end else begin
      if (strobes.take) pinLevel <= pinSync;
      pinChange <= strobes.take && mismatch;
    end
  end

  assert_change_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    pinChange |-> (pinLevel != $past(pinLevel)));

  assert_hold_without_take_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.take |=> $stable(pinLevel));

endmodule

// File: rtl/pin_debounce.sv
module pin_debounce
  import pin_debounce_pkg::*;
#(
  parameter int COUNT_W     = 4,
  parameter int MODE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rtcTick,
  input  logic               cfgWrite,
  input  logic [COUNT_W-1:0] cfgCount,
  input  logic               cfgLarge,
  input  logic               cfgFine,
  input  logic [MODE_W-1:0]  cfgMode,
  input  logic               pinRaw,
  output logic               pinLevel,
  output logic               pinChange
);

  dbStrobe_t strobes;
  logic      mismatch;

  pin_debounce_ctrl #(
    .COUNT_W (COUNT_W),
    .MODE_W  (MODE_W),
    .SHIFT0  (1),
    .SHIFT1  (3),
    .SHIFT2  (9),
    .SHIFT3  (11)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rtcTick  (rtcTick),
    .cfgWrite (cfgWrite),
    .cfgCount (cfgCount),
    .cfgLarge (cfgLarge),
    .cfgFine  (cfgFine),
    .cfgMode  (cfgMode),
    .mismatch (mismatch),
    .strobes  (strobes)
  );

  pin_debounce_dp #(
    .SYNC_STAGES (SYNC_STAGES)
  ) dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinRaw    (pinRaw),
    .strobes   (strobes),
    .mismatch  (mismatch),
    .pinLevel  (pinLevel),
    .pinChange (pinChange)
  );

endmodule

// File: tb/pin_debounce_test.sv
module pin_debounce_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rtcTick = 1'b0;
  logic       cfgWrite = 1'b0;
  logic [3:0] cfgCount = '0;
  logic       cfgLarge = 1'b0;
  logic       cfgFine = 1'b0;
  logic [1:0] cfgMode = '0;
  logic       pinRaw = 1'b0;
  logic       pinLevel;
  logic       pinChange;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pin_debounce uut (
    .clk (clk), .rstN (rstN), .rtcTick (rtcTick), .cfgWrite (cfgWrite),
    .cfgCount (cfgCount), .cfgLarge (cfgLarge), .cfgFine (cfgFine),
    .cfgMode (cfgMode), .pinRaw (pinRaw), .pinLevel (pinLevel),
    .pinChange (pinChange)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      rtcTick = 1'b1;
      @(negedge clk);
      rtcTick = 1'b0;
    end
  endtask

  task automatic writeCfg(input int cnt, input int sel, input int mode);
    cfgCount = 4'(cnt);
    cfgLarge = sel[1];
    cfgFine  = sel[0];
    cfgMode  = 2'(mode);
    cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  function automatic int unitTicks(input int sel);
    case (sel)
      0: return 2;
      1: return 8;
      2: return 512;
      default: return 2048;
    endcase
  endfunction

  initial begin
    repeat (300000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int lvl;
    int n;
    idle(3);
    // R1: reset state
    check("R1 level", pinLevel, 0);
    check("R1 change", pinChange, 0);
    rstN = 1'b1;
    idle(2);

    // R2/R3: pass-through after reset, exact latency, ticks ignored
    pinRaw = 1'b1;
    rtcTick = 1'b1;
    idle(2);
    check("R2 level after two edges", pinLevel, 0);
    idle(1);
    rtcTick = 1'b0;
    check("R3 level after three edges", pinLevel, 1);
    check("R8 strobe on change", pinChange, 1);
    idle(1);
    check("R8 strobe single cycle", pinChange, 0);
    pinRaw = 1'b0;
    idle(3);
    check("R3 falling passes", pinLevel, 0);

    // R4/R5/R9: sweep timebases and counts
    lvl = 0;
    for (int sel = 0; sel < 4; sel++) begin
      for (int ci = 0; ci < 3; ci++) begin
        int cnt;
        cnt = (ci == 0) ? 0 : (ci == 1) ? 3 : 15;
        writeCfg(cnt, sel, 1 + ((sel * 3 + ci) % 3));
        n = (cnt + 1) * unitTicks(sel);
        pinRaw = 1'(1 - lvl);
        idle(3);
        check("R5 held before ticks", pinLevel, lvl);
        tick(n - 1);
        check("R4 R5 not early", pinLevel, lvl);
        check("R8 no strobe early", pinChange, 0);
        tick(1);
        check("R4 R5 accepted on window tick", pinLevel, 1 - lvl);
        check("R8 strobe on accept", pinChange, 1);
        lvl = 1 - lvl;
      end
    end

    // R10: ticks while steady do not count
    writeCfg(1, 0, 3);
    tick(10);
    check("R10 steady level", pinLevel, lvl);
    pinRaw = 1'(1 - lvl);
    idle(3);
    tick(3);
    check("R10 full window still needed", pinLevel, lvl);
    tick(1);
    check("R10 accepted", pinLevel, 1 - lvl);
    lvl = 1 - lvl;

    // R6: bounce restarts the window
    writeCfg(0, 1, 2);
    pinRaw = 1'(1 - lvl);
    idle(3);
    tick(7);
    pinRaw = 1'(lvl);
    idle(3);
    check("R6 glitch rejected", pinLevel, lvl);
    check("R6 no strobe on glitch", pinChange, 0);
    pinRaw = 1'(1 - lvl);
    idle(3);
    tick(7);
    check("R6 restarted window", pinLevel, lvl);
    tick(1);
    check("R6 accepted after full window", pinLevel, 1 - lvl);
    lvl = 1 - lvl;

    // R7: configuration write restarts the window
    writeCfg(2, 0, 1);
    pinRaw = 1'(1 - lvl);
    idle(3);
    tick(5);
    writeCfg(2, 0, 1);
    tick(5);
    check("R7 write restarted window", pinLevel, lvl);
    tick(1);
    check("R7 accepted after full window", pinLevel, 1 - lvl);
    lvl = 1 - lvl;

    // R3: back to pass-through, ticks ignored
    writeCfg(15, 3, 0);
    pinRaw = 1'(1 - lvl);
    idle(2);
    check("R3 latency two edges", pinLevel, lvl);
    idle(1);
    check("R3 pass-through", pinLevel, 1 - lvl);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule